// File: doc/BRIEF.md
# Dual-Read Single-Write Integer Register File

This block is the general-purpose integer register store for a scalar pipeline. The decode stage supplies two source indices and gets both operand values back within the same cycle, with no clock edge in between. The writeback stage supplies a destination index, a data word and an enable, and the update happens on the next rising clock edge.

A decode read and a writeback write can land on the same register in the same cycle. In that case the read port does not take its value from the storage cells. A bypass mux passes the incoming write data straight to the read output. Index zero is a constant-zero register: it always reads as zero, writes to it are dropped, and the bypass never fires for it. Operand forwarding from later pipeline stages is handled outside this block.

Top module: `regfile_2r1w`

## Requirements
- R1: While reset is high, every register is cleared, so after reset every read index returns zero.
- R2: When write enable is high on a rising clock edge, the register at the write index (other than index 0) takes the write data. After that edge, reads of that index return it.
- R3: When write enable is low on a clock edge, no register changes.
- R4: Each read port returns the stored value of its own index. The output is combinational in the index and does not depend on the other read port.
- R5: When write enable is high, the write index is nonzero and a read index equals it, that read port returns the incoming write data in the same cycle.
- R6: Index 0 always reads as zero. A write to index 0 changes no register, and it does not bypass to a read of index 0 in the same cycle.
- R7: When write enable is low and a read index equals the write index, the read returns the stored value and not the write data.
- R8: Both read ports may address the same index, or both may collide with the write in the same cycle. Each port returns the same correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| rd_idx_a | input | 5 | Index for read port A |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_a | output | 32 | Operand value from read port A |
| rd_data_b | output | 32 | Operand value from read port B |
| wr_en | input | 1 | Write enable from writeback |
| wr_idx | input | 5 | Destination index |
| wr_data | input | 32 | Destination data |

## Verification
The assertions assume that the indices, the write enable and the write data are known, not X, whenever reset is low. They also assume these inputs hold steady between clock edges, because the bypass and write-through checks compare the current read output with the write data as it stood at the edge. The bench meets both assumptions by driving every input to a defined value from time zero. It changes inputs only on the falling edge and samples outputs shortly before the next rising edge.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int unsigned RF_DEPTH  = 32;
    localparam int unsigned RF_WIDTH  = 32;
    localparam int unsigned RF_IDX_W  = $clog2(RF_DEPTH);
    localparam int unsigned RF_PORTS  = 2;

    typedef logic [RF_IDX_W-1:0] rf_idx_t;
    typedef logic [RF_WIDTH-1:0] rf_word_t;

    typedef struct packed {
        logic     en;
        rf_idx_t  idx;
        rf_word_t data;
    } rf_wr_t;

    // Source selection for a read port.
    typedef enum logic [1:0] {
        SRC_ZERO   = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_STORE  = 2'd2
    } rf_src_e;

    function automatic rf_src_e rf_pick_src(rf_idx_t rd, rf_wr_t wr);
        if (rd == '0)
            return SRC_ZERO;
        else if (wr.en && (wr.idx == rd))
            return SRC_BYPASS;
        else
            return SRC_STORE;
    endfunction
endpackage

// File: rtl/regfile_store.sv
module regfile_store
    import regfile_pkg::*;
#(
    parameter int unsigned DEPTH = RF_DEPTH,
    parameter int unsigned WIDTH = RF_WIDTH,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] cells [DEPTH]
);
    // Entry 0 is a constant; entries 1.. are real flops.
    assign cells[0] = '0;

    for (genvar g = 1; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                cells[g] <= wr_data;
        end
    end

    // R3: with write enable low, storage is frozen across the edge
    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cells[1]) && $stable(cells[DEPTH-1]));

    // R2: an enabled write to a nonzero index lands in storage
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IW'(DEPTH-1)) |=> cells[DEPTH-1] == $past(wr_data));
endmodule

// File: rtl/regfile_rdport.sv
module regfile_rdport
    import regfile_pkg::*;
#(
    parameter int unsigned DEPTH = RF_DEPTH,
    parameter int unsigned WIDTH = RF_WIDTH,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    rd_idx,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] cells [DEPTH],
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] stored;
    logic             zero_sel;
    logic             byp_sel;

    assign stored   = cells[rd_idx];
    assign zero_sel = (rd_idx == '0);
    assign byp_sel  = wr_en && (wr_idx == rd_idx) && !zero_sel;

    always_comb begin
        unique case ({zero_sel, byp_sel})
            2'b10:   rd_data = '0;
            2'b01:   rd_data = wr_data;
            default: rd_data = stored;
        endcase
    end

    // R6: index zero reads zero even when a write targets it
    assert_zero_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == '0) |-> rd_data == '0);

    // R5: a colliding read returns what the storage will hold after the edge
    assert_bypass_matches_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == rd_idx && rd_idx != '0) |=>
            cells[$past(rd_idx)] == $past(rd_data));

    // R7: without a write, a read equals the storage
    assert_no_bypass_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> rd_data == cells[rd_idx]);
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
    import regfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [RF_IDX_W-1:0] rd_idx_a,
    input  logic [RF_IDX_W-1:0] rd_idx_b,
    output logic [RF_WIDTH-1:0] rd_data_a,
    output logic [RF_WIDTH-1:0] rd_data_b,
    input  logic                wr_en,
    input  logic [RF_IDX_W-1:0] wr_idx,
    input  logic [RF_WIDTH-1:0] wr_data
);
    rf_wr_t                wr;
    logic [RF_WIDTH-1:0]   cells [RF_DEPTH];
    logic [RF_IDX_W-1:0]   rd_idx [RF_PORTS];
    logic [RF_WIDTH-1:0]   rd_data [RF_PORTS];

    assign wr = '{en: wr_en, idx: wr_idx, data: wr_data};
    assign rd_idx[0] = rd_idx_a;
    assign rd_idx[1] = rd_idx_b;
    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    regfile_store #(.DEPTH(RF_DEPTH), .WIDTH(RF_WIDTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr.en), .wr_idx(wr.idx), .wr_data(wr.data),
        .cells(cells)
    );

    for (genvar p = 0; p < RF_PORTS; p++) begin : g_port
        regfile_rdport #(.DEPTH(RF_DEPTH), .WIDTH(RF_WIDTH)) u_port (
            .clk(clk), .rst(rst),
            .rd_idx(rd_idx[p]),
            .wr_en(wr.en), .wr_idx(wr.idx), .wr_data(wr.data),
            .cells(cells),
            .rd_data(rd_data[p])
        );
    end

    // R8: two ports on the same index agree
    assert_ports_agree_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == rd_idx_b) |-> rd_data_a == rd_data_b);

    // R1: the cycle after reset, all reads are zero
    assert_reset_clears_R1: assert property (@(posedge clk)
        $fell(rst) |-> rd_data_a == '0 && rd_data_b == '0);

    // R5/R6 on the selector used by the package helper
    assert_src_zero_R6: assert property (@(posedge clk) disable iff (rst)
        rf_pick_src(rd_idx_a, wr) == SRC_ZERO |-> rd_data_a == '0);
endmodule

// File: tb/test_regfile_2r1w.sv
module test_regfile_2r1w;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data_a, rd_data_b;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    regfile_2r1w i_regfile_2r1w (
        .clk(clk), .rst(rst),
        .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply inputs at falling edge, sample 1ns before rising edge
    task automatic step_to_sample();
        @(negedge clk);
    endtask

    task automatic settle();
        #(CLK_PERIOD/2 - 1);
    endtask

    task automatic do_write(logic [4:0] idx, logic [31:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        if (idx != 0) model[idx] = d;
        wr_en = 1'b0;
    endtask

    task automatic test_reset_R1();
        for (int i = 0; i < 32; i++) begin
            rd_idx_a = 5'(i); rd_idx_b = 5'(31 - i);
            settle();
            check("R1 port a", rd_data_a, 32'h0);
            check("R1 port b", rd_data_b, 32'h0);
            @(negedge clk);
        end
    endtask

    task automatic test_write_read_R2_R4();
        for (int i = 1; i < 32; i++)
            do_write(5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101));
        for (int i = 0; i < 32; i++) begin
            rd_idx_a = 5'(i); rd_idx_b = 5'((i * 7 + 3) % 32);
            settle();
            check("R2 readback a", rd_data_a, model[i]);
            check("R4 independent b", rd_data_b, model[(i * 7 + 3) % 32]);
            @(negedge clk);
        end
    endtask

    task automatic test_idle_R3();
        wr_en = 1'b0; wr_idx = 5'd9; wr_data = 32'hDEADBEEF;
        @(negedge clk); @(negedge clk);
        wr_idx = 5'd0;
        rd_idx_a = 5'd9; rd_idx_b = 5'd10;
        settle();
        check("R3 idle a", rd_data_a, model[9]);
        check("R3 idle b", rd_data_b, model[10]);
        @(negedge clk);
    endtask

    task automatic test_bypass_R5();
        rd_idx_a = 5'd17; rd_idx_b = 5'd4;
        wr_en = 1'b1; wr_idx = 5'd17; wr_data = 32'h12345678;
        settle();
        check("R5 bypass a", rd_data_a, 32'h12345678);
        check("R5 other port b", rd_data_b, model[4]);
        @(negedge clk);
        model[17] = 32'h12345678;
        wr_en = 1'b0;
        settle();
        check("R5 committed a", rd_data_a, 32'h12345678);
        @(negedge clk);
        rd_idx_a = 5'd31; rd_idx_b = 5'd31;
        wr_en = 1'b1; wr_idx = 5'd31; wr_data = 32'hCAFEF00D;
        settle();
        check("R8 both bypass a", rd_data_a, 32'hCAFEF00D);
        check("R8 both bypass b", rd_data_b, 32'hCAFEF00D);
        @(negedge clk);
        model[31] = 32'hCAFEF00D;
        wr_en = 1'b0;
    endtask

    task automatic test_zero_R6();
        rd_idx_a = 5'd0; rd_idx_b = 5'd0;
        wr_en = 1'b1; wr_idx = 5'd0; wr_data = 32'hFFFFFFFF;
        settle();
        check("R6 bypass blocked a", rd_data_a, 32'h0);
        check("R6 bypass blocked b", rd_data_b, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        settle();
        check("R6 zero after write", rd_data_a, 32'h0);
        @(negedge clk);
        for (int i = 1; i < 32; i++) begin
            rd_idx_a = 5'(i);
            settle();
            check("R6 no stray write", rd_data_a, model[i]);
            @(negedge clk);
        end
    endtask

    task automatic test_no_enable_R7();
        rd_idx_a = 5'd12; rd_idx_b = 5'd12;
        wr_en = 1'b0; wr_idx = 5'd12; wr_data = 32'h0BADF00D;
        settle();
        check("R7 stored a", rd_data_a, model[12]);
        check("R8 same index b", rd_data_b, model[12]);
        @(negedge clk);
        settle();
        check("R7 unchanged", rd_data_a, model[12]);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset_R1();
        test_write_read_R2_R4();
        test_idle_R3();
        test_bypass_R5();
        test_zero_R6();
        test_no_enable_R7();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule